// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit processor core. It offers two combinational read ports and one clocked write port over sixteen registers. Registers 0 to 12 are shared by every operating mode. Register 13 (stack pointer) and register 14 (link register) each have one physical copy per exception mode, plus one copy that User and System modes share. Register 15 is the program counter. It is stored here, and the caller advances it through the write port.

The block also holds the current status word, which carries the flags, the interrupt masks and a 5-bit mode code. Each exception mode has its own saved status word. When the exception-entry input is pulsed, the block does three things on one clock edge: it copies the current status into the target mode's saved status, it writes the return address into the target mode's link register, and it switches the mode. When the return input is pulsed, the block copies the active mode's saved status back into the current status. The earlier mode, and with it the earlier register bank, then becomes active again.

Top module: `mode_banked_regfile`

## Requirements
- R1: Synchronous active-high reset loads the current status with 32'h0000_00D3. This value means Supervisor mode with bit 7 (IRQ mask) and bit 6 (FIQ mask) set. Reset also clears every data register, every banked copy, every saved status and the program counter to zero.
- R2: Registers 0 to 12 are shared by all modes. A write to one of them updates it on the rising edge, and that value reads back in any mode.
- R3: Register 13 selects a stack-pointer copy based on the mode held in status bits [4:0]. The mode codes are: User 5'h10, System 5'h1F, FIQ 5'h11, IRQ 5'h12, Supervisor 5'h13, Abort 5'h17 and Undefined 5'h1B. User and System share one copy. Each of the other five modes has its own copy.
- R4: Register 14 is banked in the same way as register 13.
- R5: Register 15 is the program counter. It changes only when the write port targets address 15, and its value appears on both read ports and on the program-counter output.
- R6: In User or System mode, the saved-status output reads zero and a saved-status write is ignored. In an exception mode, that write updates the active mode's saved status.
- R7: A cycle with the exception input high and an exception-mode target does three things on the next edge. It stores the pre-edge current status into the target's saved status, it stores the return address into the target's link register, and it replaces the current mode field with the target code. All other status bits are kept. This has priority over the current-status and saved-status write inputs and over the return input in that cycle.
- R8: A return pulse in an exception mode copies that mode's saved status into the current status. The pulse has priority over a current-status write in the same cycle. In User or System mode, a return pulse has no effect.
- R9: If a register write targets register 14 of the bank that a same-cycle exception entry also writes, the return address is stored and the write data is dropped.
- R10: A mode code not listed in R3 behaves as User mode. It uses the shared User/System copies of registers 13 and 14, and it has no saved status.
- R11: An exception pulse whose target is User, System or an unlisted code changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr_a | input | 4 | Register number for read port A |
| rd_data_a | output | DATA_W | Read data A, combinational |
| rd_addr_b | input | 4 | Register number for read port B |
| rd_data_b | output | DATA_W | Read data B, combinational |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register number to write |
| wr_data | input | DATA_W | Register write data |
| pc_out | output | DATA_W | Current program counter |
| st_wr_en | input | 1 | Current-status write strobe |
| st_wr_data | input | 32 | Current-status write data |
| sv_wr_en | input | 1 | Saved-status write strobe for the active mode |
| sv_wr_data | input | 32 | Saved-status write data |
| exc_take | input | 1 | Exception-entry pulse |
| exc_mode | input | 5 | Target mode code for exception entry |
| exc_ret_addr | input | DATA_W | Return address stored into the target link register |
| exc_return | input | 1 | Exception-return pulse |
| cur_status | output | 32 | Current status word |
| saved_status | output | 32 | Saved status of the active mode, zero in User/System |

## Verification
Exception entry can fall in the same clock cycle as an ordinary register write, a status write or a return pulse. The clash that matters most is when a write to register 14 lands on the very bank the entry is loading. The random phase drives all of these inputs together at chosen rates, so collisions occur often. Directed steps then force the exact register-14 collision and an entry that coincides with a status write. After each edge, the bench reads back registers 13 and 14, the current status and the saved status through the ports. It compares them with a model that applies the entry-wins priority.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

    localparam int STW = 32;

    typedef logic [4:0] mode_t;

    localparam mode_t MD_USR = 5'h10;
    localparam mode_t MD_FIQ = 5'h11;
    localparam mode_t MD_IRQ = 5'h12;
    localparam mode_t MD_SVC = 5'h13;
    localparam mode_t MD_ABT = 5'h17;
    localparam mode_t MD_UND = 5'h1B;
    localparam mode_t MD_SYS = 5'h1F;

    typedef enum logic [2:0] {
        BK_SHARED = 3'd0,
        BK_FIQ    = 3'd1,
        BK_IRQ    = 3'd2,
        BK_SVC    = 3'd3,
        BK_ABT    = 3'd4,
        BK_UND    = 3'd5
    } bank_e;

    localparam int NBANK = 6;

    typedef struct packed {
        logic [3:0]  flags;
        logic [19:0] rsvd;
        logic        irq_off;
        logic        fiq_off;
        logic        aux;
        mode_t       mode;
    } status_t;

    localparam status_t STATUS_RESET = '{flags: 4'h0, rsvd: 20'h0, irq_off: 1'b1,
                                         fiq_off: 1'b1, aux: 1'b0, mode: MD_SVC};

    function automatic bank_e bank_of(input mode_t m);
        case (m)
            MD_FIQ:  return BK_FIQ;
            MD_IRQ:  return BK_IRQ;
            MD_SVC:  return BK_SVC;
            MD_ABT:  return BK_ABT;
            MD_UND:  return BK_UND;
            default: return BK_SHARED;
        endcase
    endfunction

endpackage

// File: rtl/mbrf_shared.sv
module mbrf_shared
    import mbrf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NSHARED = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [3:0]        rd_addr_a,
    input  logic [3:0]        rd_addr_b,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b,
    output logic [DATA_W-1:0] pc_q
);
    localparam logic [3:0] PC_IDX = 4'd15;

    logic [DATA_W-1:0] regs [NSHARED];

    for (genvar g = 0; g < NSHARED; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (wr_en && wr_addr == 4'(g)) begin
                regs[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (wr_en && wr_addr == PC_IDX) begin
            pc_q <= wr_data;
        end
    end

    always_comb begin
        rd_a = '0;
        rd_b = '0;
        if (int'(rd_addr_a) < NSHARED) rd_a = regs[rd_addr_a];
        if (int'(rd_addr_b) < NSHARED) rd_b = regs[rd_addr_b];
    end

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == PC_IDX) |=> $stable(pc_q)) else $error("pc moved"); // R5

endmodule

// File: rtl/mbrf_banked.sv
module mbrf_banked
    import mbrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sp,
    input  logic              wr_lr,
    input  logic [DATA_W-1:0] wr_data,
    input  bank_e             cur_bank,
    input  logic              exc_ok,
    input  bank_e             exc_bank,
    input  logic [DATA_W-1:0] exc_addr,
    output logic [DATA_W-1:0] sp_cur,
    output logic [DATA_W-1:0] lr_cur
);
    logic [DATA_W-1:0] sp_all [NBANK];
    logic [DATA_W-1:0] lr_all [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [DATA_W-1:0] sp_r;
        logic [DATA_W-1:0] lr_r;
        always_ff @(posedge clk) begin
            if (rst) begin
                sp_r <= '0;
                lr_r <= '0;
            end else begin
                if (wr_sp && cur_bank == bank_e'(g)) sp_r <= wr_data;
                if (exc_ok && exc_bank == bank_e'(g)) begin
                    lr_r <= exc_addr;
                end else if (wr_lr && cur_bank == bank_e'(g)) begin
                    lr_r <= wr_data;
                end
            end
        end
        assign sp_all[g] = sp_r;
        assign lr_all[g] = lr_r;
    end

    assign sp_cur = sp_all[cur_bank];
    assign lr_cur = lr_all[cur_bank];

    AST_EXC_LINK: assert property (@(posedge clk) disable iff (rst)
        exc_ok |=> lr_all[$past(exc_bank)] == $past(exc_addr)) else $error("link not loaded"); // R9

endmodule

// File: rtl/mbrf_status.sv
module mbrf_status
    import mbrf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    st_wr_en,
    input  status_t st_wr_data,
    input  logic    sv_wr_en,
    input  status_t sv_wr_data,
    input  logic    exc_ok,
    input  bank_e   exc_bank,
    input  mode_t   exc_mode,
    input  logic    exc_return,
    output status_t cur_q,
    output status_t saved_sel,
    output bank_e   cur_bank
);
    status_t saved [NBANK];
    status_t cur_nxt;

    assign cur_bank  = bank_of(cur_q.mode);
    assign saved_sel = saved[cur_bank];

    always_comb begin
        cur_nxt = cur_q;
        if (exc_ok) begin
            cur_nxt.mode = exc_mode;
        end else if (exc_return && cur_bank != BK_SHARED) begin
            cur_nxt = saved_sel;
        end else if (st_wr_en) begin
            cur_nxt = st_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= STATUS_RESET;
            for (int i = 0; i < NBANK; i++) saved[i] <= '0;
        end else begin
            cur_q <= cur_nxt;
            if (exc_ok) begin
                saved[exc_bank] <= cur_q;
            end else if (sv_wr_en && cur_bank != BK_SHARED) begin
                saved[cur_bank] <= sv_wr_data;
            end
        end
    end

    AST_RESET_STATUS: assert property (@(posedge clk)
        rst |=> cur_q == STATUS_RESET) else $error("reset status"); // R1

    AST_EXC_SAVE: assert property (@(posedge clk) disable iff (rst)
        exc_ok |=> saved[$past(exc_bank)] == $past(cur_q) && cur_q.mode == $past(exc_mode))
        else $error("entry save"); // R7

    AST_RET_RESTORE: assert property (@(posedge clk) disable iff (rst)
        exc_return && !exc_ok && cur_bank != BK_SHARED |=> cur_q == $past(saved_sel))
        else $error("return restore"); // R8

    AST_NO_SAVED_SHARED: assert property (@(posedge clk) disable iff (rst)
        cur_bank == BK_SHARED |-> saved_sel == '0) else $error("saved visible"); // R6

endmodule

// File: rtl/mode_banked_regfile.sv
module mode_banked_regfile
    import mbrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [3:0]        rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] pc_out,
    input  logic              st_wr_en,
    input  logic [31:0]       st_wr_data,
    input  logic              sv_wr_en,
    input  logic [31:0]       sv_wr_data,
    input  logic              exc_take,
    input  logic [4:0]        exc_mode,
    input  logic [DATA_W-1:0] exc_ret_addr,
    input  logic              exc_return,
    output logic [31:0]       cur_status,
    output logic [31:0]       saved_status
);
    localparam logic [3:0] SP_IDX = 4'd13;
    localparam logic [3:0] LR_IDX = 4'd14;
    localparam logic [3:0] PC_IDX = 4'd15;

    bank_e             cur_bank;
    bank_e             exc_bank;
    logic              exc_ok;
    status_t           cur_q;
    status_t           saved_sel;
    logic [DATA_W-1:0] sh_a, sh_b, sp_cur, lr_cur, pc_q;

    assign exc_bank = bank_of(exc_mode);
    assign exc_ok   = exc_take && (exc_bank != BK_SHARED);

    mbrf_shared #(.DATA_W(DATA_W), .NSHARED(13)) u_shared (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .rd_a(sh_a), .rd_b(sh_b), .pc_q(pc_q)
    );

    mbrf_banked #(.DATA_W(DATA_W)) u_banked (
        .clk(clk), .rst(rst),
        .wr_sp(wr_en && wr_addr == SP_IDX), .wr_lr(wr_en && wr_addr == LR_IDX),
        .wr_data(wr_data), .cur_bank(cur_bank), .exc_ok(exc_ok), .exc_bank(exc_bank),
        .exc_addr(exc_ret_addr), .sp_cur(sp_cur), .lr_cur(lr_cur)
    );

    mbrf_status u_status (
        .clk(clk), .rst(rst), .st_wr_en(st_wr_en), .st_wr_data(status_t'(st_wr_data)),
        .sv_wr_en(sv_wr_en), .sv_wr_data(status_t'(sv_wr_data)), .exc_ok(exc_ok),
        .exc_bank(exc_bank), .exc_mode(exc_mode), .exc_return(exc_return),
        .cur_q(cur_q), .saved_sel(saved_sel), .cur_bank(cur_bank)
    );

    function automatic logic [DATA_W-1:0] pick(input logic [3:0] a, input logic [DATA_W-1:0] sh);
        case (a)
            SP_IDX:  return sp_cur;
            LR_IDX:  return lr_cur;
            PC_IDX:  return pc_q;
            default: return sh;
        endcase
    endfunction

    assign rd_data_a    = pick(rd_addr_a, sh_a);
    assign rd_data_b    = pick(rd_addr_b, sh_b);
    assign pc_out       = pc_q;
    assign cur_status   = cur_q;
    assign saved_status = saved_sel;

    AST_IGNORE_BAD_ENTRY: assert property (@(posedge clk) disable iff (rst)
        exc_take && exc_bank == BK_SHARED && !st_wr_en && !exc_return |=> $stable(cur_status))
        else $error("bad entry acted"); // R11

endmodule

// File: tb/mode_banked_regfile_test.sv
module mode_banked_regfile_test;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [W-1:0] rd_data_a, rd_data_b, wr_data = '0, pc_out, exc_ret_addr = '0;
    logic wr_en = 0, st_wr_en = 0, sv_wr_en = 0, exc_take = 0, exc_return = 0;
    logic [31:0] st_wr_data = '0, sv_wr_data = '0, cur_status, saved_status;
    logic [4:0] exc_mode = '0;

    int checks = 0;
    int errors = 0;
    string tag_ovr = "";

    always #2 clk = ~clk;

    mode_banked_regfile #(.DATA_W(W)) uut (
        .clk(clk), .rst(rst), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pc_out(pc_out), .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
        .sv_wr_en(sv_wr_en), .sv_wr_data(sv_wr_data), .exc_take(exc_take), .exc_mode(exc_mode),
        .exc_ret_addr(exc_ret_addr), .exc_return(exc_return), .cur_status(cur_status),
        .saved_status(saved_status)
    );

    // bench model
    logic [W-1:0] m_sh [13];
    logic [W-1:0] m_sp [6];
    logic [W-1:0] m_lr [6];
    logic [31:0]  m_sv [6];
    logic [W-1:0] m_pc;
    logic [31:0]  m_cur;

    function automatic int bk(input logic [4:0] m);
        case (m)
            5'h11: return 1;
            5'h12: return 2;
            5'h13: return 3;
            5'h17: return 4;
            5'h1B: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic logic [4:0] pick_mode();
        logic [4:0] list [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
        int k = int'($urandom % 8);
        if (k == 7) return 5'($urandom);
        return list[k];
    endfunction

    function automatic logic [W-1:0] exp_rd(input logic [3:0] a);
        int b = bk(m_cur[4:0]);
        if (a < 13) return m_sh[a];
        if (a == 13) return m_sp[b];
        if (a == 14) return m_lr[b];
        return m_pc;
    endfunction

    function automatic string rtag(input logic [3:0] a);
        if (tag_ovr != "") return tag_ovr;
        if (a < 13) return "R2";
        if (a == 13) return "R3";
        if (a == 14) return "R4";
        return "R5";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv, input string what);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 13; i++) m_sh[i] = '0;
        for (int i = 0; i < 6; i++) begin m_sp[i] = '0; m_lr[i] = '0; m_sv[i] = '0; end
        m_pc = '0;
        m_cur = 32'h0000_00D3;
    endtask

    // drive one cycle, check pre-edge reads, update model
    task automatic step(input logic we, input logic [3:0] wa, input logic [W-1:0] wd,
                        input logic svw, input logic [31:0] svd,
                        input logic stw, input logic [31:0] std,
                        input logic ex, input logic [4:0] em, input logic [W-1:0] ea,
                        input logic rt, input logic [3:0] ra, input logic [3:0] rb);
        int b, eb;
        logic [31:0] old_cur, nc;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        sv_wr_en = svw; sv_wr_data = svd; st_wr_en = stw; st_wr_data = std;
        exc_take = ex; exc_mode = em; exc_ret_addr = ea; exc_return = rt;
        rd_addr_a = ra; rd_addr_b = rb;
        #1;
        chk(rtag(ra), rd_data_a, exp_rd(ra), "read A");
        chk(rtag(rb), rd_data_b, exp_rd(rb), "read B");
        chk(tag_ovr != "" ? tag_ovr : "R5", pc_out, m_pc, "pc_out");
        chk(tag_ovr != "" ? tag_ovr : "R7", cur_status, m_cur, "current status");
        b = bk(m_cur[4:0]);
        chk(tag_ovr != "" ? tag_ovr : "R6", saved_status, (b == 0) ? 32'h0 : m_sv[b], "saved status");
        // next state
        eb = bk(em);
        old_cur = m_cur;
        if (we) begin
            if (wa < 13) m_sh[wa] = wd;
            else if (wa == 13) m_sp[b] = wd;
            else if (wa == 14) m_lr[b] = wd;
            else m_pc = wd;
        end
        nc = m_cur;
        if (ex && eb != 0) begin
            m_lr[eb] = ea;
            nc = {old_cur[31:5], em};
            m_sv[eb] = old_cur;
        end else begin
            if (rt && b != 0) nc = m_sv[b];
            else if (stw) nc = std;
            if (svw && b != 0) m_sv[b] = svd;
        end
        m_cur = nc;
    endtask

    task automatic idle(input logic [3:0] ra, input logic [3:0] rb);
        step(0, 0, 0, 0, 0, 0, 0, 0, 5'h10, 0, 0, ra, rb);
    endtask

    task automatic set_mode(input logic [4:0] m);
        step(0, 0, 0, 0, 0, 1, {m_cur[31:5], m}, 0, 5'h10, 0, 0, 0, 0);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        tag_ovr = "R1";
        idle(4'd15, 4'd13);
        idle(4'd14, 4'd0);
        tag_ovr = "";

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] wa = 4'($urandom);
            logic [4:0] sm = pick_mode();
            step(($urandom % 2) == 0, wa, $urandom,
                 ($urandom % 8) == 0, $urandom,
                 ($urandom % 10) == 0, {$urandom % (1 << 27), sm},
                 ($urandom % 8) == 0, pick_mode(), $urandom,
                 ($urandom % 8) == 0, 4'($urandom), 4'($urandom));
        end

        // R9: register-14 write and entry into the same bank in one cycle
        set_mode(5'h13);
        tag_ovr = "R9";
        step(1, 4'd14, 32'hAAAA_0001, 0, 0, 1, 32'hF000_0010, 1, 5'h13, 32'h0000_1234, 0, 4'd14, 4'd13);
        idle(4'd14, 4'd14);

        // R10: unlisted mode uses shared bank
        set_mode(5'h10);
        step(1, 4'd13, 32'h5151_5151, 0, 0, 0, 0, 0, 5'h10, 0, 0, 0, 0);
        tag_ovr = "R10";
        set_mode(5'h05);
        idle(4'd13, 4'd14);
        step(0, 0, 0, 1, 32'hDEAD_BEEF, 0, 0, 0, 5'h10, 0, 0, 4'd13, 4'd13);
        idle(4'd13, 4'd1);

        // R11: entry toward non-exception targets is ignored
        tag_ovr = "R11";
        step(0, 0, 0, 0, 0, 0, 0, 1, 5'h1F, 32'h7777_0000, 0, 4'd14, 4'd13);
        step(0, 0, 0, 0, 0, 0, 0, 1, 5'h02, 32'h7777_0001, 0, 4'd14, 4'd13);
        idle(4'd14, 4'd13);

        // R8: enter IRQ from User, then return
        tag_ovr = "R8";
        set_mode(5'h10);
        step(0, 0, 0, 0, 0, 0, 0, 1, 5'h12, 32'h0000_4000, 0, 4'd14, 4'd13);
        step(1, 4'd13, 32'h0000_8800, 0, 0, 1, 32'h1234_5613, 0, 5'h10, 0, 1, 4'd14, 4'd13);
        idle(4'd13, 4'd14);
        step(0, 0, 0, 0, 0, 0, 0, 0, 5'h10, 0, 1, 4'd13, 4'd14);
        idle(4'd13, 4'd14);

        // R6: saved-status write ignored in System mode
        tag_ovr = "R6";
        set_mode(5'h1F);
        step(0, 0, 0, 1, 32'h0BAD_0BAD, 0, 0, 0, 5'h10, 0, 0, 0, 0);
        idle(4'd15, 4'd12);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule